// File: doc/BRIEF.md
# Sampling Converter Sequence Controller

This block sequences a multi-channel sampling converter. A 16-bit configuration register, written and read over a simple register port, selects the conversion clock ratio, the run mode, the acquisition extension, the interrupt condition and the result placement. A start command launches a sweep over channels 0 up to `seqLast`. For each channel the controller waits out an optional acquisition extension, asks the converter for a sample with `smpStart`, and waits for its `smpDone` pulse. On that pulse it produces a result-buffer write strobe and address.

Two modes are available. In single mode the controller stops after one sweep. In continuous mode it begins a new sweep at channel 0 immediately. A sticky data-available flag is set at the end of every sweep. It can also be set every N+1 samples. Software clears the flag through a one-bit flag write port. An abort input ends any activity at once. The analog converter itself lies outside the block and is represented by the `smpStart`/`smpDone` handshake.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the configuration register reads 0x4000, and `busy`, `dataAvail` and `irq` are 0.
- R2: Configuration bits 15:13 pick the conversion clock ratio: 0→8, 1→10, 2→12, 3→14, 4→16, 5→18, 6→20, 7→40 system clocks. `convClkEn` is a one-clock pulse repeating at that period, and its count restarts when the field changes.
- R3: Register writes while `busy` is 1 leave the configuration unchanged. Writes while `busy` is 0 take effect at the next clock edge.
- R4: In single mode (bit 6 = 0) the channels 0..`seqLast` are sampled in ascending order, one buffer write each at address equal to the channel. `busy` is 0 one cycle after the last `smpDone`.
- R5: With bit 6 = 1, the last sample of a sweep is followed at once by a new sweep starting at channel 0, and `busy` stays 1.
- R6: `dataAvail` is set one cycle after the last sample of every sweep. When bit 7 = 1 it is also set one cycle after every (N+1)th sample, where N is bits 12:8. The sample count restarts at each sweep start and after each count-triggered setting.
- R7: `irq` is 1 exactly while `dataAvail` is 1 and bit 5 is 1.
- R8: With bit 4 = 1 every result write goes to address `altLoc` instead of the channel number.
- R9: When `acqExtEn` is 1, each sample request is preceded by bits 3:0 `convClkEn` pulses of acquisition extension. When `acqExtEn` is 0 there is no extension.
- R10: A flag write with data 0 clears `dataAvail`. A flag write with data 1 has no effect.
- R11: `abortReq` returns the block to idle, so `busy` is 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Configuration register write strobe |
| regWrData | input | 16 | Configuration write data |
| regRdData | output | 16 | Configuration register contents |
| flagWrEn | input | 1 | Data-available flag write strobe |
| flagWrData | input | 1 | Flag write data (0 clears) |
| altLoc | input | ADDR_W | Override buffer location |
| seqLast | input | ADDR_W | Last channel of a sweep |
| acqExtEn | input | 1 | Enables acquisition extension |
| startReq | input | 1 | Starts a sweep when idle |
| abortReq | input | 1 | Forces return to idle |
| smpDone | input | 1 | Converter sample completion pulse |
| convClkEn | output | 1 | Conversion clock enable pulse |
| smpStart | output | 1 | Sample request to the converter |
| bufWrEn | output | 1 | Result buffer write strobe |
| bufWrAddr | output | ADDR_W | Result buffer write address |
| busy | output | 1 | Conversion activity in progress |
| dataAvail | output | 1 | Sticky data-available flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a count-triggered flag interacting with a continuous restart. The sample counter must restart at each sweep boundary. A stale count would only show up as a flag on the first sample of the second sweep. The stimulus programs a sample interval of three with two channels per sweep in continuous mode, and checks the flag after every sample across two and a half sweeps. It also clears the flag after each setting, so every new set event is observed on its own.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // field positions inside the configuration register
  localparam int unsigned CFG_W       = 16;
  localparam int unsigned DIV_LSB     = 13;
  localparam int unsigned CNT_LSB     = 8;
  localparam int unsigned CNT_W       = 5;
  localparam int unsigned INTV_BIT    = 7;
  localparam int unsigned CONT_BIT    = 6;
  localparam int unsigned IEN_BIT     = 5;
  localparam int unsigned OVR_BIT     = 4;
  localparam int unsigned EXT_W       = 4;
  localparam int unsigned DIVCNT_W    = 6;

  // strobes from sequencing control to the datapath
  typedef struct packed {
    logic seqStart;   // a sweep begins at channel 0
    logic smpTaken;   // a sample result is written this cycle
    logic seqEnd;     // that sample is the last of the sweep
  } seqStrobe_t;

  // divide ratio minus one for the three-bit selector
  function automatic logic [DIVCNT_W-1:0] divRatioM1(input logic [2:0] sel);
    if (sel == 3'd7) return DIVCNT_W'(39);
    return {2'b00, sel, 1'b0} + DIVCNT_W'(7);
  endfunction

endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             abortReq,
  input  logic             smpDone,
  input  logic             convClkEn,
  input  logic             chanLast,
  input  logic             contMode,
  input  logic [EXT_W-1:0] acqExt,
  input  logic             acqExtEn,
  output logic             busy,
  output logic             smpStart,
  output logic             bufWrEn,
  output seqStrobe_t       strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_CONV} seqState_t;

  seqState_t        state, stateNext;
  logic [EXT_W-1:0] extLeft, extNext;
  logic [EXT_W-1:0] extLoad;

  assign extLoad  = acqExtEn ? acqExt : '0;
  assign busy     = (state != ST_IDLE);
  assign smpStart = (state == ST_ACQ) && (extLeft == '0);

  always_comb begin
    strobe          = '0;
    bufWrEn         = (state == ST_CONV) && smpDone;
    strobe.smpTaken = bufWrEn;
    strobe.seqEnd   = bufWrEn && chanLast;
    strobe.seqStart = !abortReq &&
                      (((state == ST_IDLE) && startReq) || (strobe.seqEnd && contMode));
  end

  always_comb begin
    stateNext = state;
    extNext   = extLeft;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          stateNext = ST_ACQ;
          extNext   = extLoad;
        end
      end
      ST_ACQ: begin
        if (extLeft == '0) begin
          stateNext = ST_CONV;
        end else if (convClkEn) begin
          extNext = extLeft - EXT_W'(1);
        end
      end
      ST_CONV: begin
        if (smpDone) begin
          if (chanLast && !contMode) begin
            stateNext = ST_IDLE;
          end else begin
            stateNext = ST_ACQ;
            extNext   = extLoad;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    if (abortReq) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      extLeft <= '0;
    end else begin
      state   <= stateNext;
      extLeft <= extNext;
    end
  end

endmodule

// File: rtl/adc_seq_path.sv
module adc_seq_path
  import adc_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter logic [15:0] RESET_CFG = 16'h4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [CFG_W-1:0]  regWrData,
  input  logic              flagWrEn,
  input  logic              flagWrData,
  input  logic [ADDR_W-1:0] altLoc,
  input  logic [ADDR_W-1:0] seqLast,
  input  logic              busy,
  input  seqStrobe_t        strobe,
  output logic [CFG_W-1:0]  cfg,
  output logic              convClkEn,
  output logic              chanLast,
  output logic [ADDR_W-1:0] bufWrAddr,
  output logic              dataAvail,
  output logic              irq
);

  // configuration register, locked while busy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cfg <= RESET_CFG;
    else if (regWrEn && !busy) cfg <= regWrData;
  end

  // conversion clock divider
  logic [2:0]          divSel, divSelQ;
  logic [DIVCNT_W-1:0] divCnt, divLimit;

  assign divSel    = cfg[DIV_LSB +: 3];
  assign divLimit  = divRatioM1(divSel);
  assign convClkEn = (divCnt == divLimit) && (divSel == divSelQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divSelQ <= RESET_CFG[DIV_LSB +: 3];
      divCnt  <= '0;
    end else begin
      divSelQ <= divSel;
      if ((divSel != divSelQ) || (divCnt == divLimit)) divCnt <= '0;
      else                                             divCnt <= divCnt + DIVCNT_W'(1);
    end
  end

  // channel pointer and buffer address
  logic [ADDR_W-1:0] chan;

  assign chanLast  = (chan == seqLast);
  assign bufWrAddr = cfg[OVR_BIT] ? altLoc : chan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                chan <= '0;
    else if (strobe.seqStart) chan <= '0;
    else if (strobe.smpTaken) chan <= chan + ADDR_W'(1);
  end

  // sample interval counter
  logic [CNT_W-1:0] smpCnt;
  logic             countHit;

  assign countHit = strobe.smpTaken && cfg[INTV_BIT] && (smpCnt == cfg[CNT_LSB +: CNT_W]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                smpCnt <= '0;
    else if (strobe.seqStart) smpCnt <= '0;
    else if (countHit)        smpCnt <= '0;
    else if (strobe.smpTaken) smpCnt <= smpCnt + CNT_W'(1);
  end

  // sticky data-available flag, setting wins over clearing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         dataAvail <= 1'b0;
    else if (countHit || strobe.seqEnd) dataAvail <= 1'b1;
    else if (flagWrEn && !flagWrData)  dataAvail <= 1'b0;
  end

  assign irq = dataAvail && cfg[IEN_BIT];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  input  logic              flagWrEn,
  input  logic              flagWrData,
  input  logic [ADDR_W-1:0] altLoc,
  input  logic [ADDR_W-1:0] seqLast,
  input  logic              acqExtEn,
  input  logic              startReq,
  input  logic              abortReq,
  input  logic              smpDone,
  output logic              convClkEn,
  output logic              smpStart,
  output logic              bufWrEn,
  output logic [ADDR_W-1:0] bufWrAddr,
  output logic              busy,
  output logic              dataAvail,
  output logic              irq
);

  seqStrobe_t       strobe;
  logic [CFG_W-1:0] cfg;
  logic             chanLast;

  assign regRdData = cfg;

  adc_seq_fsm i_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .abortReq (abortReq),
    .smpDone  (smpDone),
    .convClkEn(convClkEn),
    .chanLast (chanLast),
    .contMode (cfg[CONT_BIT]),
    .acqExt   (cfg[EXT_W-1:0]),
    .acqExtEn (acqExtEn),
    .busy     (busy),
    .smpStart (smpStart),
    .bufWrEn  (bufWrEn),
    .strobe   (strobe)
  );

  adc_seq_path #(.ADDR_W(ADDR_W)) i_path (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .flagWrEn  (flagWrEn),
    .flagWrData(flagWrData),
    .altLoc    (altLoc),
    .seqLast   (seqLast),
    .busy      (busy),
    .strobe    (strobe),
    .cfg       (cfg),
    .convClkEn (convClkEn),
    .chanLast  (chanLast),
    .bufWrAddr (bufWrAddr),
    .dataAvail (dataAvail),
    .irq       (irq)
  );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [15:0]       regRdData,
  input logic [ADDR_W-1:0] altLoc,
  input logic              abortReq,
  input logic              convClkEn,
  input logic              smpStart,
  input logic              bufWrEn,
  input logic [ADDR_W-1:0] bufWrAddr,
  input logic              busy,
  input logic              dataAvail,
  input logic              irq
);

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    convClkEn |=> !convClkEn);

  assert_write_lock_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn) |=> $stable(regRdData));

  assert_write_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> busy);

  assert_irq_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> dataAvail);

  assert_addr_override_R8: assert property (@(posedge clk) disable iff (!rstN)
    (bufWrEn && regRdData[4]) |-> (bufWrAddr == altLoc));

  assert_request_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    smpStart |-> busy);

  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> !busy);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regRdData(regRdData),
  .altLoc   (altLoc),
  .abortReq (abortReq),
  .convClkEn(convClkEn),
  .smpStart (smpStart),
  .bufWrEn  (bufWrEn),
  .bufWrAddr(bufWrAddr),
  .busy     (busy),
  .dataAvail(dataAvail),
  .irq      (irq)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
  localparam int ADDR_W = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rstN;
  logic              regWrEn, flagWrEn, flagWrData, acqExtEn;
  logic              startReq, abortReq, smpDone;
  logic [15:0]       regWrData, regRdData;
  logic [ADDR_W-1:0] altLoc, seqLast, bufWrAddr;
  logic              convClkEn, smpStart, bufWrEn, busy, dataAvail, irq;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  adc_seq_ctrl #(.ADDR_W(ADDR_W)) i_adc_seq_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .altLoc(altLoc), .seqLast(seqLast), .acqExtEn(acqExtEn),
    .startReq(startReq), .abortReq(abortReq), .smpDone(smpDone),
    .convClkEn(convClkEn), .smpStart(smpStart), .bufWrEn(bufWrEn),
    .bufWrAddr(bufWrAddr), .busy(busy), .dataAvail(dataAvail), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance to the next falling edge and drop all one-cycle strobes
  task automatic step();
    @(negedge clk);
    regWrEn  = 1'b0;
    flagWrEn = 1'b0;
    startReq = 1'b0;
    abortReq = 1'b0;
    smpDone  = 1'b0;
  endtask

  task automatic writeReg(input logic [15:0] v);
    regWrEn   = 1'b1;
    regWrData = v;
    step();
  endtask

  task automatic startSeq();
    startReq = 1'b1;
    step();
  endtask

  // one converter sample: wait for the request, answer, check address and flag
  task automatic doSample(input int expAddr, input bit expFlag, input int expAcq,
                          input bit clr, input string req);
    int acq   = 0;
    int guard = 0;
    while (!smpStart && guard < 2000) begin
      if (convClkEn) acq++;
      step();
      guard++;
    end
    chk(smpStart == 1'b1, req, int'(smpStart), 1);
    if (expAcq >= 0) chk(acq == expAcq, "R9 acquisition pulses", acq, expAcq);
    step();
    smpDone = 1'b1;
    #1;
    chk(bufWrEn && (int'(bufWrAddr) == expAddr), req, int'(bufWrAddr), expAddr);
    step();
    chk(dataAvail == expFlag, req, int'(dataAvail), int'(expFlag));
    if (clr && dataAvail) begin
      flagWrEn   = 1'b1;
      flagWrData = 1'b0;
    end
  endtask

  task automatic measRatio(input int exp, input string req);
    int g = 0;
    int n = 0;
    while (!convClkEn && g < 100) begin step(); g++; end
    step();
    n = 1;
    while (!convClkEn && n < 100) begin step(); n++; end
    chk(n == exp, req, n, exp);
  endtask

  task automatic testReset();
    chk(regRdData == 16'h4000, "R1 reset config", int'(regRdData), 16'h4000);
    chk(!busy, "R1 reset busy", int'(busy), 0);
    chk(!dataAvail && !irq, "R1 reset flag", int'(dataAvail), 0);
    measRatio(12, "R2 reset ratio");
  endtask

  task automatic testDivider();
    writeReg(16'h0000); measRatio(8,  "R2 ratio sel0");
    writeReg(16'h6000); measRatio(14, "R2 ratio sel3");
    writeReg(16'hA000); measRatio(18, "R2 ratio sel5");
    writeReg(16'hE000); measRatio(40, "R2 ratio sel7");
  endtask

  task automatic testSingle();
    writeReg(16'h0000);
    seqLast = 3;
    startSeq();
    for (int c = 0; c < 4; c++) doSample(c, c == 3, 0, 1'b0, "R4 single sweep");
    chk(!busy, "R4 idle after sweep", int'(busy), 0);
    chk(!irq, "R7 irq disabled", int'(irq), 0);
    flagWrEn = 1'b1; flagWrData = 1'b1; step();
    chk(dataAvail, "R10 write one keeps flag", int'(dataAvail), 1);
    flagWrEn = 1'b1; flagWrData = 1'b0; step();
    chk(!dataAvail, "R10 write zero clears", int'(dataAvail), 0);
  endtask

  task automatic testIrq();
    writeReg(16'h0020);
    seqLast = 0;
    startSeq();
    doSample(0, 1'b1, 0, 1'b0, "R7 sweep flag");
    chk(irq, "R7 irq asserted", int'(irq), 1);
    flagWrEn = 1'b1; flagWrData = 1'b0; step();
    chk(!irq, "R7 irq follows flag", int'(irq), 0);
  endtask

  task automatic testOverride();
    writeReg(16'h0010);
    altLoc  = 21;
    seqLast = 2;
    startSeq();
    for (int c = 0; c < 3; c++) doSample(21, c == 2, 0, 1'b1, "R8 override address");
    step();
  endtask

  task automatic testAcqExt();
    writeReg(16'h0003);
    acqExtEn = 1'b1;
    seqLast  = 1;
    startSeq();
    for (int c = 0; c < 2; c++) doSample(c, c == 1, 3, 1'b1, "R9 extension on");
    step();
    acqExtEn = 1'b0;
    startSeq();
    for (int c = 0; c < 2; c++) doSample(c, c == 1, 0, 1'b1, "R9 extension off");
    step();
  endtask

  task automatic testCount();
    writeReg(16'h0180);   // interval mode, N = 1
    seqLast = 4;
    startSeq();
    doSample(0, 1'b0, 0, 1'b1, "R6 count sample1");
    doSample(1, 1'b1, 0, 1'b1, "R6 count sample2");
    doSample(2, 1'b0, 0, 1'b1, "R6 count sample3");
    doSample(3, 1'b1, 0, 1'b1, "R6 count sample4");
    doSample(4, 1'b1, 0, 1'b1, "R6 sweep end");
    step();
  endtask

  task automatic testContinuous();
    writeReg(16'h02C0);   // continuous, interval mode, N = 2
    seqLast = 1;
    startSeq();
    doSample(0, 1'b0, 0, 1'b1, "R5 sweep1 ch0");
    doSample(1, 1'b1, 0, 1'b1, "R5 sweep1 end");
    chk(busy, "R5 busy after restart", int'(busy), 1);
    doSample(0, 1'b0, 0, 1'b1, "R6 count restarts at sweep");
    doSample(1, 1'b1, 0, 1'b1, "R5 sweep2 end");
    doSample(0, 1'b0, 0, 1'b1, "R5 sweep3 ch0");
    abortReq = 1'b1;
    step();
    chk(!busy, "R11 abort to idle", int'(busy), 0);
  endtask

  task automatic testLock();
    writeReg(16'h000F);
    acqExtEn = 1'b1;
    seqLast  = 0;
    startSeq();
    writeReg(16'h2000);
    chk(regRdData == 16'h000F, "R3 write ignored while busy", int'(regRdData), 16'h000F);
    abortReq = 1'b1;
    step();
    writeReg(16'h2000);
    chk(regRdData == 16'h2000, "R3 write accepted when idle", int'(regRdData), 16'h2000);
    acqExtEn = 1'b0;
  endtask

  initial begin
    rstN = 1'b0;
    regWrEn = 1'b0; regWrData = '0; flagWrEn = 1'b0; flagWrData = 1'b0;
    altLoc = '0; seqLast = '0; acqExtEn = 1'b0;
    startReq = 1'b0; abortReq = 1'b0; smpDone = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDivider();
    testSingle();
    testIrq();
    testOverride();
    testAcqExt();
    testCount();
    testContinuous();
    testLock();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule